// File: doc/BRIEF.md
# Region-Based Memory Access Firewall

This block guards one memory target port. Each incoming read or write is compared with a small table of address regions. Software programs the table through a simple register write port. Every region has a control word, an inclusive lower and upper address, and three permission entries. Each entry pairs an initiator identifier with sixteen grant bits. These bits cover the four combinations of security state and privilege level, and for each combination they grant write, read, cacheable and debug access separately.

Regions come in two kinds. Background regions give default permissions over a wide span. Foreground regions that cover the same address take precedence over them. A request that passes is forwarded to memory, and its read data returns unchanged. A request that fails is not forwarded. A failed read returns zero with an error response. The block also latches an exception record holding the faulting address and the initiator's attributes, and it raises an interrupt. The first fault is held until software clears it. Any later faults only set an overflow flag.

Top module: `mem_region_guard`

## Requirements
- R1: After reset every region is disabled, no exception is pending, `irq` is low, and every request is blocked.
- R2: A region takes part in matching only when bits 3:0 of its control word equal 0xA. Any other value disables the region, whatever its bounds and permissions hold.
- R3: A region covers the addresses from its start value to its end value, both included. The addresses just outside either end are not covered.
- R4: A permission entry holds the initiator ID in bits 23:16 and the grant bits in bits 15:0. ID 0xC3 matches any initiator. The region grants a request when at least one of its three entries both matches the ID and has the required grant bit set.
- R5: The grant nibble is chosen by security and privilege. Bits 3:0 are secure user, 7:4 secure privileged, 11:8 non-secure user and 15:12 non-secure privileged. Within a nibble, bit 0 grants write, bit 1 read, bit 2 cacheable and bit 3 debug. A debug request uses bit 3 only.
- R6: When control bit 9 is set, a cacheable non-debug request is judged by bit 2 of its nibble alone. When bit 9 is clear, a cacheable request is judged by the read or write bit, like any other request.
- R7: Control bit 8 marks a region as background. If any enabled foreground region covers the address, the lowest-numbered such region decides. Otherwise the lowest-numbered covering background region decides.
- R8: A passed request asserts `mem_valid`, and `rsp_rdata` carries `mem_rdata`. A blocked request keeps `mem_valid` low, raises `rsp_err` and returns zero on `rsp_rdata`.
- R9: On the clock edge after a blocked request, with no exception pending, the record is loaded. `exc_addr` gets the address. `exc_info` gets the initiator ID in bits 7:0, write in bit 8, secure in bit 9, privileged in bit 10, cacheable in bit 11, debug in bit 12 and the firewall number in bits 31:24. `irq` is then high.
- R10: While an exception is pending, its record is held. A further blocked request sets `exc_overflow`. `exc_clear` empties the record and clears the overflow flag.
- R11: An address covered by no enabled region is blocked (default setting of `NOMATCH_ALLOW`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_region | input | RIDX_W | Region index to write |
| cfg_field | input | 3 | 0 control, 1 start, 2 end, 3..5 permission entry 0..2 |
| cfg_wdata | input | AW | Write data |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Request address |
| req_id | input | 8 | Initiator identifier |
| req_secure | input | 1 | Secure request |
| req_priv | input | 1 | Privileged request |
| req_cache | input | 1 | Cacheable request |
| req_debug | input | 1 | Debug request |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_rdata | input | DW | Read data from memory |
| rsp_err | output | 1 | Request blocked |
| rsp_rdata | output | DW | Read data returned to initiator |
| exc_clear | input | 1 | Clear the exception record |
| exc_valid | output | 1 | Exception record holds a fault |
| exc_overflow | output | 1 | Further faults arrived while one was pending |
| exc_addr | output | AW | Faulting address |
| exc_info | output | 32 | Faulting initiator attributes and firewall number |
| irq | output | 1 | Violation interrupt |

## Verification
The bench goes after several corner cases. It probes the exact start and end addresses of overlapping regions and their neighbours. An exclusive bound, or an overlap resolved by the higher region number, would show up there. It sweeps every mix of security, privilege, direction, cacheability and debug against IDs that do and do not match, and against the wildcard. A design that picks the wrong nibble or grant bit would then pass or block the wrong class. The bench flips the cache-aware bit and the enable key of a region. A design that ignores either would keep its old decision. Faults are spread between clears, so a design that overwrote the held record or failed to flag overflow would show a wrong address or flag.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int          NUM_PERM    = 3;
   localparam logic [7:0]  WILDCARD_ID = 8'hC3;
   localparam logic [3:0]  ENABLE_KEY  = 4'hA;
   localparam int          CTRL_BG_BIT = 8;
   localparam int          CTRL_CA_BIT = 9;

   // field selector of the table write port
   localparam logic [2:0]  FLD_CTRL  = 3'd0;
   localparam logic [2:0]  FLD_START = 3'd1;
   localparam logic [2:0]  FLD_END   = 3'd2;
   localparam logic [2:0]  FLD_PERM0 = 3'd3;

   typedef struct packed {
      logic [7:0]  id;
      logic [15:0] grant;
   } perm_t;

   typedef struct packed {
      logic en;
      logic bg;
      logic cache_aware;
   } rctl_t;

   // bit within a nibble that a request needs
   function automatic logic [1:0] need_bit(input logic wr, input logic cache,
                                           input logic dbg, input logic cache_aware);
      if (dbg)                     return 2'd3;
      else if (cache_aware && cache) return 2'd2;
      else if (wr)                 return 2'd0;
      else                         return 2'd1;
   endfunction
endpackage

// File: rtl/rgn_table.sv
module rgn_table
   import rgn_guard_pkg::*;
#(
   parameter int NREG   = 4,
   parameter int AW     = 32,
   parameter int RIDX_W = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                we,
   input  logic [RIDX_W-1:0]                   region,
   input  logic [2:0]                          field,
   input  logic [AW-1:0]                       wdata,
   output rctl_t [NREG-1:0]                    ctl_o,
   output logic  [NREG-1:0][AW-1:0]            lo_o,
   output logic  [NREG-1:0][AW-1:0]            hi_o,
   output perm_t [NREG-1:0][NUM_PERM-1:0]      perm_o
);
   timeunit 1ns;
   timeprecision 1ps;

   for (genvar r = 0; r < NREG; r++) begin : g_rgn
      logic sel;
      assign sel = we && (region == RIDX_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_o[r] <= '0;
            lo_o[r]  <= '0;
            hi_o[r]  <= '0;
         end else if (sel) begin
            if (field == FLD_CTRL) begin
               ctl_o[r].en          <= (wdata[3:0] == ENABLE_KEY);
               ctl_o[r].bg          <= wdata[CTRL_BG_BIT];
               ctl_o[r].cache_aware <= wdata[CTRL_CA_BIT];
            end
            if (field == FLD_START) lo_o[r] <= wdata;
            if (field == FLD_END)   hi_o[r] <= wdata;
         end
      end

      for (genvar e = 0; e < NUM_PERM; e++) begin : g_perm
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               perm_o[r][e] <= '0;
            else if (sel && field == FLD_PERM0 + 3'(e))
               perm_o[r][e] <= wdata[23:0];
         end
      end
   end
endmodule

// File: rtl/rgn_check.sv
module rgn_check
   import rgn_guard_pkg::*;
#(
   parameter int AW = 32
) (
   input  rctl_t                      ctl,
   input  logic [AW-1:0]              lo,
   input  logic [AW-1:0]              hi,
   input  perm_t [NUM_PERM-1:0]       perm,
   input  logic [AW-1:0]              addr,
   input  logic [7:0]                 id,
   input  logic                       secure,
   input  logic                       priv,
   input  logic                       wr,
   input  logic                       cache,
   input  logic                       dbg,
   output logic                       hit,
   output logic                       pass
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [3:0] gidx;

   assign hit  = ctl.en && (addr >= lo) && (addr <= hi);
   // nibble select {~secure, priv}, bit select from request kind
   assign gidx = {~secure, priv, need_bit(wr, cache, dbg, ctl.cache_aware)};

   always_comb begin
      pass = 1'b0;
      for (int e = 0; e < NUM_PERM; e++) begin
         if ((perm[e].id == id || perm[e].id == WILDCARD_ID) && perm[e].grant[gidx])
            pass = 1'b1;
      end
   end
endmodule

// File: rtl/rgn_exc_capture.sv
module rgn_exc_capture #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          viol,
   input  logic          clear,
   input  logic [AW-1:0] addr,
   input  logic [31:0]   info,
   output logic          valid,
   output logic          overflow,
   output logic [AW-1:0] addr_q,
   output logic [31:0]   info_q
);
   timeunit 1ns;
   timeprecision 1ps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         overflow <= 1'b0;
         addr_q   <= '0;
         info_q   <= '0;
      end else if (viol && (!valid || clear)) begin
         valid    <= 1'b1;
         overflow <= 1'b0;
         addr_q   <= addr;
         info_q   <= info;
      end else if (viol) begin
         overflow <= 1'b1;
      end else if (clear) begin
         valid    <= 1'b0;
         overflow <= 1'b0;
      end
   end
endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
   import rgn_guard_pkg::*;
#(
   parameter int         NREG          = 4,
   parameter int         AW            = 32,
   parameter int         DW            = 32,
   parameter logic [7:0] FW_ID         = 8'h01,
   parameter bit         NOMATCH_ALLOW = 1'b0,
   localparam int        RIDX_W        = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [RIDX_W-1:0] cfg_region,
   input  logic [2:0]        cfg_field,
   input  logic [AW-1:0]     cfg_wdata,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [7:0]        req_id,
   input  logic              req_secure,
   input  logic              req_priv,
   input  logic              req_cache,
   input  logic              req_debug,
   output logic              mem_valid,
   input  logic [DW-1:0]     mem_rdata,
   output logic              rsp_err,
   output logic [DW-1:0]     rsp_rdata,
   input  logic              exc_clear,
   output logic              exc_valid,
   output logic              exc_overflow,
   output logic [AW-1:0]     exc_addr,
   output logic [31:0]       exc_info,
   output logic              irq
);
   timeunit 1ns;
   timeprecision 1ps;

   if (NREG < 1 || NREG > 64) begin : g_bad_nreg
      $error("NREG out of range");
   end
   if (AW < 24 || AW > 64) begin : g_bad_aw
      $error("AW must hold a permission entry and stay at most 64");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   rctl_t [NREG-1:0]                ctl;
   logic  [NREG-1:0][AW-1:0]        lo, hi;
   perm_t [NREG-1:0][NUM_PERM-1:0]  perm;
   logic  [NREG-1:0]                hit, pass;

   rgn_table #(.NREG(NREG), .AW(AW), .RIDX_W(RIDX_W)) i_table (
      .clk, .rst_n,
      .we(cfg_we), .region(cfg_region), .field(cfg_field), .wdata(cfg_wdata),
      .ctl_o(ctl), .lo_o(lo), .hi_o(hi), .perm_o(perm)
   );

   for (genvar r = 0; r < NREG; r++) begin : g_chk
      rgn_check #(.AW(AW)) i_rgn (
         .ctl(ctl[r]), .lo(lo[r]), .hi(hi[r]), .perm(perm[r]),
         .addr(req_addr), .id(req_id), .secure(req_secure), .priv(req_priv),
         .wr(req_write), .cache(req_cache), .dbg(req_debug),
         .hit(hit[r]), .pass(pass[r])
      );
   end

   // lowest-numbered foreground hit wins, then lowest-numbered background hit
   logic fg_any, fg_pass, bg_any, bg_pass, nomatch_pass, allow;
   always_comb begin
      fg_any = 1'b0; fg_pass = 1'b0;
      bg_any = 1'b0; bg_pass = 1'b0;
      for (int r = NREG - 1; r >= 0; r--) begin
         if (hit[r] && !ctl[r].bg) begin
            fg_any  = 1'b1;
            fg_pass = pass[r];
         end
         if (hit[r] && ctl[r].bg) begin
            bg_any  = 1'b1;
            bg_pass = pass[r];
         end
      end
   end

   if (NOMATCH_ALLOW) begin : g_open
      assign nomatch_pass = 1'b1;
   end else begin : g_closed
      assign nomatch_pass = 1'b0;
   end

   assign allow     = fg_any ? fg_pass : (bg_any ? bg_pass : nomatch_pass);
   assign mem_valid = req_valid && allow;
   assign rsp_err   = req_valid && !allow;
   assign rsp_rdata = allow ? mem_rdata : '0;

   logic [31:0] info_now;
   assign info_now = {FW_ID, 11'd0, req_debug, req_cache, req_priv, req_secure,
                      req_write, req_id};

   rgn_exc_capture #(.AW(AW)) i_exc (
      .clk, .rst_n,
      .viol(rsp_err), .clear(exc_clear), .addr(req_addr), .info(info_now),
      .valid(exc_valid), .overflow(exc_overflow), .addr_q(exc_addr), .info_q(exc_info)
   );

   assign irq = exc_valid;
endmodule

// File: rtl/rgn_guard_chk.sv
module rgn_guard_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic          mem_valid,
   input logic          rsp_err,
   input logic [DW-1:0] rsp_rdata,
   input logic          exc_clear,
   input logic          exc_valid,
   input logic          exc_overflow,
   input logic [AW-1:0] exc_addr
);
   timeunit 1ns;
   timeprecision 1ps;

   assert_block_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0) && !mem_valid);

   assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (mem_valid != rsp_err));

   assert_capture_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err && !exc_valid) |=> exc_valid && (exc_addr == $past(req_addr)));

   assert_hold_record_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && !exc_clear) |=> exc_valid && $stable(exc_addr));

   assert_overflow_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && !exc_clear && rsp_err) |=> exc_overflow);

   assert_overflow_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_overflow |-> exc_valid);
endmodule

bind mem_region_guard rgn_guard_chk #(.AW(AW), .DW(DW)) i_guard_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .mem_valid(mem_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
   .exc_clear(exc_clear), .exc_valid(exc_valid), .exc_overflow(exc_overflow),
   .exc_addr(exc_addr)
);

// File: tb/test_mem_region_guard.sv
module test_mem_region_guard;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NR = 4;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_region = '0;
   logic [2:0]  cfg_field = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0]  req_id = '0;
   logic        req_secure = 1'b0, req_priv = 1'b0, req_cache = 1'b0, req_debug = 1'b0;
   logic        mem_valid, rsp_err, exc_valid, exc_overflow, irq;
   logic [31:0] mem_rdata, rsp_rdata, exc_addr, exc_info;
   logic        exc_clear = 1'b0;

   int total = 0, bad = 0;

   always #10 clk = ~clk;   // 20 ns period
   assign mem_rdata = {16'hD00D, req_addr[15:0]};

   mem_region_guard i_mem_region_guard (
      .clk, .rst_n, .cfg_we, .cfg_region, .cfg_field, .cfg_wdata,
      .req_valid, .req_write, .req_addr, .req_id, .req_secure, .req_priv,
      .req_cache, .req_debug, .mem_valid, .mem_rdata, .rsp_err, .rsp_rdata,
      .exc_clear, .exc_valid, .exc_overflow, .exc_addr, .exc_info, .irq
   );

   // shadow of the programmed table
   logic        sh_en [NR], sh_bg [NR], sh_ca [NR];
   logic [31:0] sh_lo [NR], sh_hi [NR];
   logic [7:0]  sh_id [NR][3];
   logic [15:0] sh_g  [NR][3];
   // expected exception record
   logic        m_valid = 1'b0, m_ovf = 1'b0;
   logic [31:0] m_addr = '0, m_info = '0;

   initial begin
      for (int r = 0; r < NR; r++) begin
         sh_en[r] = 0; sh_bg[r] = 0; sh_ca[r] = 0; sh_lo[r] = 0; sh_hi[r] = 0;
         for (int e = 0; e < 3; e++) begin sh_id[r][e] = 0; sh_g[r][e] = 0; end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit region_pass(input int r, input logic [31:0] a, input logic [7:0] id,
                                      input bit s, input bit p, input bit w, input bit c,
                                      input bit d);
      int nib, b;
      nib = (s ? 0 : 8) + (p ? 4 : 0);
      b = d ? 3 : ((sh_ca[r] && c) ? 2 : (w ? 0 : 1));
      for (int e = 0; e < 3; e++)
         if ((sh_id[r][e] == id || sh_id[r][e] == 8'hC3) && sh_g[r][e][nib + b]) return 1;
      return 0;
   endfunction

   function automatic bit exp_allow(input logic [31:0] a, input logic [7:0] id, input bit s,
                                    input bit p, input bit w, input bit c, input bit d);
      for (int r = 0; r < NR; r++)
         if (sh_en[r] && !sh_bg[r] && a >= sh_lo[r] && a <= sh_hi[r])
            return region_pass(r, a, id, s, p, w, c, d);
      for (int r = 0; r < NR; r++)
         if (sh_en[r] && sh_bg[r] && a >= sh_lo[r] && a <= sh_hi[r])
            return region_pass(r, a, id, s, p, w, c, d);
      return 0;
   endfunction

   task automatic cfg(input int r, input int f, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_region = 2'(r); cfg_field = 3'(f); cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 0;
      case (f)
         0: begin sh_en[r] = (d[3:0] == 4'hA); sh_bg[r] = d[8]; sh_ca[r] = d[9]; end
         1: sh_lo[r] = d;
         2: sh_hi[r] = d;
         default: begin sh_id[r][f-3] = d[23:16]; sh_g[r][f-3] = d[15:0]; end
      endcase
   endtask

   task automatic exc_check(input string tag);
      check(exc_valid === m_valid && exc_overflow === m_ovf && irq === m_valid,
            {tag, " flags"}, {exc_valid, exc_overflow, irq}, {m_valid, m_ovf, m_valid});
      if (m_valid)
         check(exc_addr === m_addr && exc_info === m_info, {tag, " record"},
               {exc_addr, exc_info}, {m_addr, m_info});
   endtask

   task automatic do_req(input logic [31:0] a, input logic [7:0] id, input bit s, input bit p,
                         input bit w, input bit c, input bit d, input string tag);
      bit ok;
      logic [31:0] er;
      ok = exp_allow(a, id, s, p, w, c, d);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_id = id; req_secure = s; req_priv = p;
      req_write = w; req_cache = c; req_debug = d;
      #2;
      er = ok ? {16'hD00D, a[15:0]} : 32'h0;
      check(mem_valid === ok && rsp_err === !ok && rsp_rdata === er, {tag, " decision"},
            {mem_valid, rsp_err, rsp_rdata}, {ok, !ok, er});
      @(posedge clk); #1;
      req_valid = 0;
      if (!ok) begin
         if (!m_valid) begin
            m_valid = 1; m_ovf = 0; m_addr = a;
            m_info = {8'h01, 11'd0, d, c, p, s, w, id};
         end else m_ovf = 1;
      end
      exc_check({tag, " exception"});
   endtask

   task automatic clr();
      @(negedge clk); exc_clear = 1;
      @(posedge clk); #1; exc_clear = 0;
      m_valid = 0; m_ovf = 0;
      exc_check("R10 clear");
   endtask

   function automatic logic [31:0] pick_addr(input int i);
      case (i)
         0: return 32'h0FFF;  1: return 32'h1000;  2: return 32'h13FF;  3: return 32'h1400;
         4: return 32'h147F;  5: return 32'h1480;  6: return 32'h14FF;  7: return 32'h1500;
         8: return 32'h15FF;  9: return 32'h1600; 10: return 32'h1FFF; 11: return 32'h2000;
         12: return 32'h3000; default: return 32'h3800;
      endcase
   endfunction

   function automatic logic [7:0] pick_id(input int i);
      case (i)
         0: return 8'h00; 1: return 8'h02; 2: return 8'h05;
         3: return 8'h07; 4: return 8'h09; default: return 8'hC3;
      endcase
   endfunction

   initial begin
      #(200000 * 20);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state
      exc_check("R1 reset");
      do_req(32'h1000, 8'hC3, 0, 1, 0, 0, 0, "R1 empty table");
      clr();

      // background region 0
      cfg(0, 0, 32'h10A); cfg(0, 1, 32'h1000); cfg(0, 2, 32'h1FFF);
      cfg(0, 3, 32'hC3_0002); cfg(0, 4, 32'h05_FFFF); cfg(0, 5, 32'h00_0000);
      // foreground region 1, cache-aware
      cfg(1, 0, 32'h20A); cfg(1, 1, 32'h1400); cfg(1, 2, 32'h14FF);
      cfg(1, 3, 32'hC3_8C88); cfg(1, 4, 32'h07_3333); cfg(1, 5, 32'h09_0F00);
      // foreground region 2, overlapping region 1
      cfg(2, 0, 32'h00A); cfg(2, 1, 32'h1480); cfg(2, 2, 32'h15FF);
      cfg(2, 3, 32'h02_00F0); cfg(2, 4, 32'hC3_1111); cfg(2, 5, 32'h00_0000);
      // region 3, wrong enable key
      cfg(3, 0, 32'h00B); cfg(3, 1, 32'h3000); cfg(3, 2, 32'h3FFF);
      cfg(3, 3, 32'hC3_FFFF); cfg(3, 4, 32'hC3_FFFF); cfg(3, 5, 32'hC3_FFFF);

      // sweep: bounds R3, entries R4, nibbles R5, cache R6, priority R7, no-hit R11
      for (int ai = 0; ai < 14; ai++)
         for (int ii = 0; ii < 6; ii++)
            for (int m = 0; m < 32; m++) begin
               do_req(pick_addr(ai), pick_id(ii), m[0], m[1], m[2], m[3], m[4],
                      "R3 R4 R5 R6 R7 R11 sweep");
               n++;
               if (n % 7 == 0) clr();
            end

      // R2: disabled region grants nothing, enabling it changes the result
      clr();
      do_req(32'h3004, 8'h11, 0, 0, 0, 0, 0, "R2 key 0xB blocks");
      cfg(3, 0, 32'h00A);
      do_req(32'h3004, 8'h11, 0, 0, 0, 0, 0, "R2 key 0xA allows");
      cfg(3, 0, 32'h005);
      do_req(32'h3004, 8'h11, 0, 0, 1, 0, 0, "R2 key 0x5 blocks");

      // R6: cache-aware toggle on region 1 (0x8C88 gives non-secure user cacheable)
      clr();
      do_req(32'h1410, 8'h00, 0, 0, 0, 1, 0, "R6 cacheable read aware");
      do_req(32'h1410, 8'h00, 0, 0, 0, 0, 0, "R6 plain read aware");
      cfg(1, 0, 32'h00A);
      do_req(32'h1410, 8'h00, 0, 0, 0, 1, 0, "R6 cacheable read unaware");

      // R8/R9/R10 sequence: first fault held, second sets overflow
      clr();
      do_req(32'h0800, 8'h3A, 1, 1, 1, 0, 1, "R9 first fault");
      do_req(32'h0900, 8'h3B, 0, 0, 0, 0, 0, "R10 second fault");
      do_req(32'h1004, 8'h44, 1, 0, 0, 0, 0, "R8 allowed read");
      clr();
      do_req(32'h0A00, 8'h5C, 0, 1, 0, 1, 0, "R9 fault after clear");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule